// File: doc/BRIEF.md
# Pin Output Drive Register Bank

This block holds the output value, the output enable and the drive mode of a set of general-purpose pins. Software reaches it through a plain register bus: one access per cycle, a write is taken on the clock edge, and read data follows the address combinationally. The pins are split into a full 32-bit low group, which covers pins 0 to 31, and a narrower high group, which covers the remaining pins.

Each group has a read/write value register and a read/write enable register. Each of these has two write-only companions. One sets the bits written as 1 and the other clears them, so a single pin can be changed without a read-modify-write sequence.

Every pin also has a configuration word that holds a drive-mode bit. In push-pull mode the pad enable follows the enable register. In open-drain mode the pad is driven only while it should pull low, and a value of 1 releases the line.

Top module: `gpo_bank`

## Requirements
- R1: After reset every value bit, enable bit and drive-mode bit is 0, so padOe is all zero and every register reads 0.
- R2: Offset 0x04 is the low value register. A write stores all 32 bits, it reads back unchanged, and padOut[31:0] shows the new value from the clock edge that takes the write.
- R3: Offset 0x10 is the high value register. Its bits 7:0 hold pins 32 to 39 and drive padOut[39:32]. Bits 31:8 read as 0 and ignore writes.
- R4: A write to a set alias (0x08 low value, 0x14 high value) forces to 1 each target bit whose written bit is 1. All other bits keep their value.
- R5: A write to a clear alias (0x0C low value, 0x18 high value) forces to 0 each target bit whose written bit is 1. All other bits keep their value.
- R6: The enable registers are at 0x20 (low) and 0x2C (high, bits 7:0). Their set aliases are at 0x24 and 0x30, and their clear aliases are at 0x28 and 0x34. They follow the same rules as R2 to R5.
- R7: A read of any set or clear alias returns 0.
- R8: Pin n has a configuration word at 0x88 + 4*n. Bit 2 is the drive mode: 0 selects push-pull and 1 selects open-drain. It appears on padOdMode[n]. All other bits read 0.
- R9: For a push-pull pin, padOe equals the pin's enable bit.
- R10: For an open-drain pin, padOe is 1 only when the enable bit is 1 and the value bit is 0.
- R11: A write to an unmapped or misaligned address changes nothing, and a read of one returns 0.
- R12: No state changes in a cycle unless both busValid and busWrite are 1. A read (busWrite 0) leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busValid | input | 1 | Access valid in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| padOut | output | 40 | Output value per pin |
| padOe | output | 40 | Pad output enable per pin |
| padOdMode | output | 40 | Open-drain mode per pin |

## Verification
The bench builds the block with its default of 40 pins and a 12-bit address. This leaves the high group 8 bits wide, so the reserved bits 31:8 of the high registers can be written and checked. The 40 configuration words end at 0x124, so the decoder's upper bound is exercised and addresses just past it must read as zero. Random writes spread over every alias, the pin words and unmapped slots build mixed push-pull and open-drain states, so every combination of enable, value and drive mode is reached.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

  localparam int LO_BITS = 32;
  localparam int OD_BIT  = 2;

  localparam int OFS_OUT_LO     = 'h004;
  localparam int OFS_OUT_LO_SET = 'h008;
  localparam int OFS_OUT_LO_CLR = 'h00C;
  localparam int OFS_OUT_HI     = 'h010;
  localparam int OFS_OUT_HI_SET = 'h014;
  localparam int OFS_OUT_HI_CLR = 'h018;
  localparam int OFS_EN_LO      = 'h020;
  localparam int OFS_EN_LO_SET  = 'h024;
  localparam int OFS_EN_LO_CLR  = 'h028;
  localparam int OFS_EN_HI      = 'h02C;
  localparam int OFS_EN_HI_SET  = 'h030;
  localparam int OFS_EN_HI_CLR  = 'h034;
  localparam int OFS_PIN_BASE   = 'h088;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_WRITE,
    OP_SET,
    OP_CLR
  } wrOp_e;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_OUT_LO,
    RD_OUT_HI,
    RD_EN_LO,
    RD_EN_HI,
    RD_PIN
  } rdSel_e;

  typedef struct packed {
    wrOp_e        outLoOp;
    wrOp_e        outHiOp;
    wrOp_e        enLoOp;
    wrOp_e        enHiOp;
    logic         pinWr;
    logic [7:0]   pinIdx;
    rdSel_e       rdSel;
  } strobe_t;

endpackage

// File: rtl/gpo_ctrl.sv
module gpo_ctrl
  import gpo_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] PIN_LO = ADDR_W'(OFS_PIN_BASE);
  localparam logic [ADDR_W-1:0] PIN_HI = ADDR_W'(OFS_PIN_BASE + 4 * NUM_PINS);

  logic wrEn;
  logic inPinRange;
  logic [ADDR_W-1:0] pinOfs;

  assign wrEn       = busValid & busWrite;
  assign inPinRange = (busAddr >= PIN_LO) && (busAddr < PIN_HI) && (busAddr[1:0] == 2'b00);
  assign pinOfs     = busAddr - PIN_LO;

  always_comb begin
    strb         = '0;
    strb.outLoOp = OP_NONE;
    strb.outHiOp = OP_NONE;
    strb.enLoOp  = OP_NONE;
    strb.enHiOp  = OP_NONE;
    strb.rdSel   = RD_ZERO;
    strb.pinIdx  = 8'(pinOfs >> 2);
    case (busAddr)
      ADDR_W'(OFS_OUT_LO): begin
        strb.rdSel = RD_OUT_LO;
        if (wrEn) strb.outLoOp = OP_WRITE;
      end
      ADDR_W'(OFS_OUT_LO_SET): if (wrEn) strb.outLoOp = OP_SET;
      ADDR_W'(OFS_OUT_LO_CLR): if (wrEn) strb.outLoOp = OP_CLR;
      ADDR_W'(OFS_OUT_HI): begin
        strb.rdSel = RD_OUT_HI;
        if (wrEn) strb.outHiOp = OP_WRITE;
      end
      ADDR_W'(OFS_OUT_HI_SET): if (wrEn) strb.outHiOp = OP_SET;
      ADDR_W'(OFS_OUT_HI_CLR): if (wrEn) strb.outHiOp = OP_CLR;
      ADDR_W'(OFS_EN_LO): begin
        strb.rdSel = RD_EN_LO;
        if (wrEn) strb.enLoOp = OP_WRITE;
      end
      ADDR_W'(OFS_EN_LO_SET): if (wrEn) strb.enLoOp = OP_SET;
      ADDR_W'(OFS_EN_LO_CLR): if (wrEn) strb.enLoOp = OP_CLR;
      ADDR_W'(OFS_EN_HI): begin
        strb.rdSel = RD_EN_HI;
        if (wrEn) strb.enHiOp = OP_WRITE;
      end
      ADDR_W'(OFS_EN_HI_SET): if (wrEn) strb.enHiOp = OP_SET;
      ADDR_W'(OFS_EN_HI_CLR): if (wrEn) strb.enHiOp = OP_CLR;
      default: begin
        if (inPinRange) begin
          strb.rdSel = RD_PIN;
          strb.pinWr = wrEn;
        end
      end
    endcase
  end

  // R12
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.outLoOp != OP_NONE, strb.outHiOp != OP_NONE,
              strb.enLoOp != OP_NONE, strb.enHiOp != OP_NONE, strb.pinWr}));

  // R12
  no_write_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    !(busValid && busWrite) |->
      (strb.outLoOp == OP_NONE && strb.outHiOp == OP_NONE &&
       strb.enLoOp == OP_NONE && strb.enHiOp == OP_NONE && !strb.pinWr));

  // R11
  pin_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    strb.pinWr |-> (int'(strb.pinIdx) < NUM_PINS));

endmodule

// File: rtl/gpo_datapath.sv
module gpo_datapath
  import gpo_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strb,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOdMode
);

  localparam int HI_BITS = NUM_PINS - LO_BITS;

  logic [NUM_PINS-1:0] outVal;
  logic [NUM_PINS-1:0] enVal;
  logic [NUM_PINS-1:0] odMode;

  function automatic logic nextBit(logic cur, wrOp_e op, logic d);
    case (op)
      OP_WRITE: return d;
      OP_SET:   return cur | d;
      OP_CLR:   return cur & ~d;
      default:  return cur;
    endcase
  endfunction

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam bit IS_LO = (i < LO_BITS);
    localparam int BIDX  = IS_LO ? i : i - LO_BITS;
    wrOp_e outOp;
    wrOp_e enOp;
    assign outOp = IS_LO ? strb.outLoOp : strb.outHiOp;
    assign enOp  = IS_LO ? strb.enLoOp  : strb.enHiOp;

    always_ff @(posedge clk) begin
      if (rst) begin
        outVal[i] <= 1'b0;
        enVal[i]  <= 1'b0;
        odMode[i] <= 1'b0;
      end else begin
        outVal[i] <= nextBit(outVal[i], outOp, busWdata[BIDX]);
        enVal[i]  <= nextBit(enVal[i], enOp, busWdata[BIDX]);
        if (strb.pinWr && strb.pinIdx == 8'(i))
          odMode[i] <= busWdata[OD_BIT];
      end
    end

    assign padOe[i] = enVal[i] & ~(odMode[i] & outVal[i]);
  end

  assign padOut    = outVal;
  assign padOdMode = odMode;

  always_comb begin
    busRdata = '0;
    case (strb.rdSel)
      RD_OUT_LO: busRdata[LO_BITS-1:0] = outVal[LO_BITS-1:0];
      RD_OUT_HI: busRdata[HI_BITS-1:0] = outVal[NUM_PINS-1:LO_BITS];
      RD_EN_LO:  busRdata[LO_BITS-1:0] = enVal[LO_BITS-1:0];
      RD_EN_HI:  busRdata[HI_BITS-1:0] = enVal[NUM_PINS-1:LO_BITS];
      RD_PIN: begin
        for (int i = 0; i < NUM_PINS; i++)
          if (strb.pinIdx == 8'(i)) busRdata[OD_BIT] = odMode[i];
      end
      default: busRdata = '0;
    endcase
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (outVal == '0 && enVal == '0 && odMode == '0));

  // R4
  set_lo_hits_chk: assert property (@(posedge clk) disable iff (rst)
    strb.outLoOp == OP_SET |=>
      ((outVal[LO_BITS-1:0] & $past(busWdata)) == $past(busWdata)));

  // R4
  set_lo_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    strb.outLoOp == OP_SET |=>
      ((outVal[LO_BITS-1:0] & ~$past(busWdata)) ==
       ($past(outVal[LO_BITS-1:0]) & ~$past(busWdata))));

  // R5
  clr_lo_hits_chk: assert property (@(posedge clk) disable iff (rst)
    strb.outLoOp == OP_CLR |=> ((outVal[LO_BITS-1:0] & $past(busWdata)) == '0));

  // R6
  clr_en_lo_chk: assert property (@(posedge clk) disable iff (rst)
    strb.enLoOp == OP_CLR |=> ((enVal[LO_BITS-1:0] & $past(busWdata)) == '0));

  // R12
  value_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.outLoOp == OP_NONE && strb.outHiOp == OP_NONE) |=> $stable(outVal));

  // R10
  oe_within_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (padOe & ~enVal) == '0);

endmodule

// File: rtl/gpo_bank.sv
module gpo_bank
  import gpo_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOdMode
);

  strobe_t strb;

  gpo_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  gpo_datapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padOut    (padOut),
    .padOe     (padOe),
    .padOdMode (padOdMode)
  );

endmodule

// File: tb/gpo_bank_test.sv
`timescale 1ns/1ps
module gpo_bank_test;

  localparam int NP = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NP-1:0] padOut, padOe, padOdMode;

  int checks = 0;
  int fails  = 0;

  logic [NP-1:0] mOut = '0;
  logic [NP-1:0] mEn  = '0;
  logic [NP-1:0] mOd  = '0;

  gpo_bank uut (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padOut(padOut), .padOe(padOe), .padOdMode(padOdMode)
  );

  always #2.5 clk = ~clk;

  function automatic bit isPin(logic [11:0] a);
    return a >= 12'h088 && a < 12'h088 + 12'(4 * NP) && a[1:0] == 2'b00;
  endfunction

  function automatic void modelApply(logic [11:0] a, logic [31:0] d);
    case (a)
      12'h004: mOut[31:0] = d;
      12'h008: mOut[31:0] = mOut[31:0] | d;
      12'h00C: mOut[31:0] = mOut[31:0] & ~d;
      12'h010: mOut[39:32] = d[7:0];
      12'h014: mOut[39:32] = mOut[39:32] | d[7:0];
      12'h018: mOut[39:32] = mOut[39:32] & ~d[7:0];
      12'h020: mEn[31:0] = d;
      12'h024: mEn[31:0] = mEn[31:0] | d;
      12'h028: mEn[31:0] = mEn[31:0] & ~d;
      12'h02C: mEn[39:32] = d[7:0];
      12'h030: mEn[39:32] = mEn[39:32] | d[7:0];
      12'h034: mEn[39:32] = mEn[39:32] & ~d[7:0];
      default: if (isPin(a)) mOd[(a - 12'h088) >> 2] = d[2];
    endcase
  endfunction

  function automatic logic [31:0] expRead(logic [11:0] a);
    case (a)
      12'h004: return mOut[31:0];
      12'h010: return {24'h0, mOut[39:32]};
      12'h020: return mEn[31:0];
      12'h02C: return {24'h0, mEn[39:32]};
      default: if (isPin(a)) return {29'h0, mOd[(a - 12'h088) >> 2], 2'b00};
    endcase
    return 32'h0;
  endfunction

  function automatic logic [NP-1:0] expOe();
    return mEn & ~(mOd & mOut);
  endfunction

  function automatic string readTag(logic [11:0] a);
    case (a)
      12'h004: return "R2";
      12'h010: return "R3";
      12'h020, 12'h02C: return "R6";
      12'h008, 12'h00C, 12'h014, 12'h018, 12'h024, 12'h028, 12'h030, 12'h034: return "R7";
      default: return isPin(a) ? "R8" : "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busAccess(logic [11:0] a, logic [31:0] d, logic v, logic w);
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    if (v && w) modelApply(a, d);
  endtask

  task automatic checkRead(logic [11:0] a);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    check(readTag(a), 64'(busRdata), 64'(expRead(a)));
    busValid = 1'b0;
  endtask

  task automatic checkPads();
    check("R2", 64'(padOut), 64'(mOut));
    check(((mOd & mEn) != '0) ? "R10" : "R9", 64'(padOe), 64'(expOe()));
    check("R8", 64'(padOdMode), 64'(mOd));
  endtask

  function automatic logic [11:0] pickAddr();
    int r = int'($urandom % 20);
    logic [11:0] regs [12] = '{12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018,
                               12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034};
    logic [11:0] holes [4] = '{12'h000, 12'h038, 12'h08A, 12'h128};
    if (r < 12) return regs[r];
    if (r < 18) return 12'h088 + 12'(4 * ($urandom % NP));
    return holes[$urandom % 4];
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1", 64'(padOe), 64'h0);
    check("R1", 64'(padOut), 64'h0);
    checkRead(12'h004); checkRead(12'h010); checkRead(12'h020); checkRead(12'h2C);
    checkRead(12'h088);

    // R3 reserved high bits
    busAccess(12'h010, 32'hFFFF_FFFF, 1, 1);
    checkRead(12'h010);
    checkPads();

    // R4 / R5 directed on low value
    busAccess(12'h004, 32'h0000_00F0, 1, 1);
    busAccess(12'h008, 32'h8000_0003, 1, 1);
    checkRead(12'h004);
    check("R4", 64'(padOut[31:0]), 64'h8000_00F3);
    busAccess(12'h00C, 32'h0000_0030, 1, 1);
    check("R5", 64'(padOut[31:0]), 64'h8000_00C3);

    // R12: invalid write and read do not change state
    busAccess(12'h004, 32'h1234_5678, 0, 1);
    busAccess(12'h004, 32'h1234_5678, 1, 0);
    check("R12", 64'(padOut[31:0]), 64'h8000_00C3);

    // R11: unmapped and misaligned writes
    busAccess(12'h038, 32'hFFFF_FFFF, 1, 1);
    busAccess(12'h005, 32'hFFFF_FFFF, 1, 1);
    busAccess(12'h128, 32'hFFFF_FFFF, 1, 1);
    check("R11", 64'(padOut), 64'(mOut));
    checkRead(12'h038); checkRead(12'h128);

    // R10 open drain on pin 35
    busAccess(12'h088 + 12'(4 * 35), 32'h4, 1, 1);
    busAccess(12'h030, 32'h08, 1, 1);
    busAccess(12'h014, 32'h08, 1, 1);
    check("R10", 64'(padOe[35]), 64'h0);
    busAccess(12'h018, 32'h08, 1, 1);
    check("R10", 64'(padOe[35]), 64'h1);
    // R7 aliases read zero
    checkRead(12'h014); checkRead(12'h024);

    // Random phase
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a = pickAddr();
      logic [31:0] d = $urandom;
      busAccess(a, d, 1, 1);
      checkPads();
      checkRead(a);
      checkRead(pickAddr());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule